// File: doc/BRIEF.md
# Hardwired Step-Sequenced Control Unit

This block drives the control lines of a small single-bus processor. A step counter advances one position per clock. A step decoder turns the count into one-hot timing lines T1..Tn. An opcode decoder turns the instruction register's opcode field into one line per instruction. An encoder then forms each control output as a sum of products of timing lines, instruction lines, the condition flags and the memory-done input. The datapath that these lines steer is outside the block.

Every instruction starts with a shared three-step fetch. After that, a short per-opcode tail runs. The unit supports a register-plus-memory add, an unconditional relative branch, and two conditional branches, one testing the negative flag and one testing the zero flag. Every other opcode is a no-op that ends at once. Asserting the end line restarts the counter at T1, so the next fetch begins. While the memory-wait line is high, the counter stalls until the memory reports completion. All pins are plain control signals, with no handshake.

Top module: `hw_ctrl_unit`

## Requirements
- R1: While `rst_n` is low, every control output is 0, and after release the sequence starts at T1.
- R2: With `run` high and no stall, the step advances by exactly one per clock cycle.
- R3: While `run` is low, every control output is 0 and the step holds its value.
- R4: Fetch for every opcode:
  - T1 asserts `pc_out`, `mar_load`, `mem_read`, `sel_const`, `alu_add` and `z_load`.
  - T2 asserts `z_out`, `pc_load`, `y_load` and `wait_mem`.
  - T3 asserts `mdr_out` and `ir_load`.
- R5: In a step that asserts `wait_mem`, the step holds while `mfc` is 0 and advances at the first clock edge where `mfc` is 1.
- R6: Opcode 0 (add) runs four more steps:
  - T4: `src_out`, `mar_load`, `mem_read`.
  - T5: `dst_out`, `y_load`, `wait_mem`.
  - T6: `mdr_out`, `alu_add`, `z_load`, with `sel_const` at 0.
  - T7: `z_out`, `dst_in`, `end_seq`.
- R7: Opcode 1 (branch) runs two more steps:
  - T4: `offset_out`, `alu_add`, `z_load`.
  - T5: `z_out`, `pc_load`, `end_seq`.
- R8: Opcode 2 tests flag bit 3 (negative) and opcode 3 tests flag bit 2 (zero).
  - If the tested bit is 1, the sequence matches R7.
  - If the tested bit is 0, T4 asserts only `end_seq`.
- R9: After a cycle in which `end_seq` is high and `run` is high, the next cycle is T1.
- R10: Opcodes 4 to 7 assert only `end_seq` in T4.
- R11: At most one of `pc_out`, `z_out`, `mdr_out`, `src_out`, `dst_out` and `offset_out` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Enables stepping and outputs |
| ir_opcode | input | 3 | Opcode field of the instruction register |
| cond_flags | input | 4 | Condition flags; bit 3 negative, bit 2 zero |
| mfc | input | 1 | Memory operation complete |
| pc_out | output | 1 | Program counter drives the bus |
| pc_load | output | 1 | Program counter loads from the bus |
| mar_load | output | 1 | Address register loads |
| mem_read | output | 1 | Memory read request |
| mdr_out | output | 1 | Data register drives the bus |
| ir_load | output | 1 | Instruction register loads |
| y_load | output | 1 | ALU operand register loads |
| sel_const | output | 1 | ALU A input takes the constant (0 selects the operand register) |
| alu_add | output | 1 | ALU adds |
| z_load | output | 1 | ALU result register loads |
| z_out | output | 1 | ALU result register drives the bus |
| src_out | output | 1 | Address source register drives the bus |
| dst_out | output | 1 | Destination register drives the bus |
| dst_in | output | 1 | Destination register loads |
| offset_out | output | 1 | Branch offset field drives the bus |
| wait_mem | output | 1 | Wait for memory completion |
| end_seq | output | 1 | Last step of the instruction |

## Verification
The bench builds the block with its defaults: an 8-position step counter, a 3-bit opcode and 4 flags. This means all four undefined opcodes and every flag combination for both conditional branches are driven. The `mfc` input is pulsed at periods of 1, 2 and 3 cycles, so both wait steps see zero-, one- and two-cycle stalls. Phases with `run` gaps and a mid-stream reset exercise holds and restarts at arbitrary steps.

// File: rtl/hwc_pkg.sv
package hwc_pkg;
  localparam int NUM_STEPS = 8;
  localparam int STEP_W    = $clog2(NUM_STEPS);
  localparam int OPC_W     = 3;
  localparam int NUM_OPS   = 1 << OPC_W;
  localparam int FLAG_W    = 4;
  localparam int FLAG_NEG  = 3;
  localparam int FLAG_ZERO = 2;

  localparam int OP_ADD = 0;
  localparam int OP_BR  = 1;
  localparam int OP_BRN = 2;
  localparam int OP_BRZ = 3;

  typedef struct packed {
    logic pc_out;
    logic pc_load;
    logic mar_load;
    logic mem_read;
    logic mdr_out;
    logic ir_load;
    logic y_load;
    logic sel_const;
    logic alu_add;
    logic z_load;
    logic z_out;
    logic src_out;
    logic dst_out;
    logic dst_in;
    logic offset_out;
    logic wait_mem;
    logic end_seq;
  } ctrl_t;
endpackage

// File: rtl/hwc_step_counter.sv
module hwc_step_counter #(
  parameter int STEPS = hwc_pkg::NUM_STEPS,
  localparam int SW = $clog2(STEPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          end_i,
  input  logic          wait_i,
  input  logic          mfc_i,
  output logic [SW-1:0] count_o
);
  logic stall;
  logic [SW-1:0] nxt;

  assign stall = wait_i && !mfc_i;

  always_comb begin
    nxt = count_o;
    if (run) begin
      if (end_i)
        nxt = '0;
      else if (!stall)
        nxt = (count_o == SW'(STEPS - 1)) ? '0 : count_o + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_o <= '0;
    else        count_o <= nxt;
  end

  p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && wait_i && !mfc_i && !end_i) |=> $stable(count_o));
  p_end_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && end_i) |=> (count_o == '0));
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(count_o));
endmodule

// File: rtl/hwc_step_decoder.sv
module hwc_step_decoder #(
  parameter int STEPS = hwc_pkg::NUM_STEPS,
  localparam int SW = $clog2(STEPS)
) (
  input  logic [SW-1:0]    count_i,
  output logic [STEPS-1:0] t_o
);
  for (genvar i = 0; i < STEPS; i++) begin : g_step
    assign t_o[i] = (count_i == SW'(i));
  end

  always_comb begin
    p_one_step_r2: assert ($countones(t_o) == 1);
  end
endmodule

// File: rtl/hwc_op_decoder.sv
module hwc_op_decoder #(
  parameter int OW = hwc_pkg::OPC_W,
  localparam int OPS = 1 << OW
) (
  input  logic [OW-1:0]  opcode_i,
  output logic [OPS-1:0] ins_o
);
  for (genvar j = 0; j < OPS; j++) begin : g_op
    assign ins_o[j] = (opcode_i == OW'(j));
  end
endmodule

// File: rtl/hwc_encoder.sv
module hwc_encoder
  import hwc_pkg::*;
#(
  parameter int STEPS = NUM_STEPS,
  parameter int OPS   = NUM_OPS,
  parameter int FW    = FLAG_W
) (
  input  logic [STEPS-1:0] t_i,
  input  logic [OPS-1:0]   ins_i,
  input  logic [FW-1:0]    flags_i,
  output ctrl_t            ctrl_o
);
  logic is_add, is_br, is_brn, is_brz, is_nop, any_br, br_go, br_skip;
  logic t1, t2, t3, t4, t5, t6, t7;

  assign t1 = t_i[0];
  assign t2 = t_i[1];
  assign t3 = t_i[2];
  assign t4 = t_i[3];
  assign t5 = t_i[4];
  assign t6 = t_i[5];
  assign t7 = t_i[6];

  assign is_add  = ins_i[OP_ADD];
  assign is_br   = ins_i[OP_BR];
  assign is_brn  = ins_i[OP_BRN];
  assign is_brz  = ins_i[OP_BRZ];
  assign is_nop  = !(is_add || is_br || is_brn || is_brz);
  assign any_br  = is_br || is_brn || is_brz;
  assign br_go   = is_br || (is_brn && flags_i[FLAG_NEG]) || (is_brz && flags_i[FLAG_ZERO]);
  assign br_skip = (is_brn && !flags_i[FLAG_NEG]) || (is_brz && !flags_i[FLAG_ZERO]);

  always_comb begin
    ctrl_o            = '0;
    ctrl_o.pc_out     = t1;
    ctrl_o.sel_const  = t1;
    ctrl_o.mar_load   = t1 | (t4 & is_add);
    ctrl_o.mem_read   = t1 | (t4 & is_add);
    ctrl_o.alu_add    = t1 | (t6 & is_add) | (t4 & br_go);
    ctrl_o.z_load     = t1 | (t6 & is_add) | (t4 & br_go);
    ctrl_o.z_out      = t2 | (t7 & is_add) | (t5 & any_br);
    ctrl_o.pc_load    = t2 | (t5 & any_br);
    ctrl_o.y_load     = t2 | (t5 & is_add);
    ctrl_o.wait_mem   = t2 | (t5 & is_add);
    ctrl_o.mdr_out    = t3 | (t6 & is_add);
    ctrl_o.ir_load    = t3;
    ctrl_o.src_out    = t4 & is_add;
    ctrl_o.dst_out    = t5 & is_add;
    ctrl_o.dst_in     = t7 & is_add;
    ctrl_o.offset_out = t4 & br_go;
    ctrl_o.end_seq    = (t7 & is_add) | (t5 & any_br) | (t4 & (br_skip | is_nop));
  end
endmodule

// File: rtl/hw_ctrl_unit.sv
module hw_ctrl_unit
  import hwc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [OPC_W-1:0]  ir_opcode,
  input  logic [FLAG_W-1:0] cond_flags,
  input  logic              mfc,
  output logic              pc_out,
  output logic              pc_load,
  output logic              mar_load,
  output logic              mem_read,
  output logic              mdr_out,
  output logic              ir_load,
  output logic              y_load,
  output logic              sel_const,
  output logic              alu_add,
  output logic              z_load,
  output logic              z_out,
  output logic              src_out,
  output logic              dst_out,
  output logic              dst_in,
  output logic              offset_out,
  output logic              wait_mem,
  output logic              end_seq
);
  logic [STEP_W-1:0]    count;
  logic [NUM_STEPS-1:0] t_lines;
  logic [NUM_OPS-1:0]   ins_lines;
  ctrl_t                raw, gated;

  hwc_step_counter #(.STEPS(NUM_STEPS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run),
    .end_i(raw.end_seq), .wait_i(raw.wait_mem), .mfc_i(mfc),
    .count_o(count)
  );

  hwc_step_decoder #(.STEPS(NUM_STEPS)) u_tdec (
    .count_i(count), .t_o(t_lines)
  );

  hwc_op_decoder #(.OW(OPC_W)) u_idec (
    .opcode_i(ir_opcode), .ins_o(ins_lines)
  );

  hwc_encoder #(.STEPS(NUM_STEPS), .OPS(NUM_OPS), .FW(FLAG_W)) u_enc (
    .t_i(t_lines), .ins_i(ins_lines), .flags_i(cond_flags), .ctrl_o(raw)
  );

  assign gated = (run && rst_n) ? raw : '0;

  assign pc_out     = gated.pc_out;
  assign pc_load    = gated.pc_load;
  assign mar_load   = gated.mar_load;
  assign mem_read   = gated.mem_read;
  assign mdr_out    = gated.mdr_out;
  assign ir_load    = gated.ir_load;
  assign y_load     = gated.y_load;
  assign sel_const  = gated.sel_const;
  assign alu_add    = gated.alu_add;
  assign z_load     = gated.z_load;
  assign z_out      = gated.z_out;
  assign src_out    = gated.src_out;
  assign dst_out    = gated.dst_out;
  assign dst_in     = gated.dst_in;
  assign offset_out = gated.offset_out;
  assign wait_mem   = gated.wait_mem;
  assign end_seq    = gated.end_seq;

  p_one_driver_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pc_out, z_out, mdr_out, src_out, dst_out, offset_out}));
  p_quiet_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (gated == '0));
  p_fetch_after_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (end_seq && run) |=> (run -> (pc_out && mar_load && mem_read)));
  p_wait_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && wait_mem && mfc && run) |=> (run -> !$stable(t_lines)));
endmodule

// File: tb/hw_ctrl_unit_bench.sv
module hw_ctrl_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic [2:0] ir_opcode = '0;
  logic [3:0] cond_flags = '0;
  logic mfc = 1'b0;
  logic pc_out, pc_load, mar_load, mem_read, mdr_out, ir_load, y_load, sel_const;
  logic alu_add, z_load, z_out, src_out, dst_out, dst_in, offset_out, wait_mem, end_seq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;
  int mstep = 0;
  bit prev_end = 1'b0;

  always #2 clk = ~clk;

  hw_ctrl_unit u_hw_ctrl_unit (
    .clk(clk), .rst_n(rst_n), .run(run), .ir_opcode(ir_opcode),
    .cond_flags(cond_flags), .mfc(mfc),
    .pc_out(pc_out), .pc_load(pc_load), .mar_load(mar_load), .mem_read(mem_read),
    .mdr_out(mdr_out), .ir_load(ir_load), .y_load(y_load), .sel_const(sel_const),
    .alu_add(alu_add), .z_load(z_load), .z_out(z_out), .src_out(src_out),
    .dst_out(dst_out), .dst_in(dst_in), .offset_out(offset_out),
    .wait_mem(wait_mem), .end_seq(end_seq)
  );

  // order: pc_out pc_load mar_load mem_read mdr_out ir_load y_load sel_const
  //        alu_add z_load z_out src_out dst_out dst_in offset_out wait_mem end_seq
  function automatic logic [16:0] expect_ctrl(int step, int op, logic [3:0] fl);
    logic [16:0] v = '0;
    bit take;
    case (step)
      0: v = 17'b1011_0001_1100_0000_0;
      1: v = 17'b0100_0010_0010_0000_1 << 1;
      2: v = 17'b0000_1100_0000_0000_0;
      default: v = '0;
    endcase
    if (step == 1) v = 17'b0100_0010_0010_0000_0 | 17'b0000_0000_0000_0001_0;
    if (step >= 3) begin
      take = (op == 1) || (op == 2 && fl[3]) || (op == 3 && fl[2]);
      if (op == 0) begin
        if (step == 3) v = 17'b0011_0000_0001_0000_0;
        if (step == 4) v = 17'b0000_0010_0000_1001_0;
        if (step == 5) v = 17'b0000_1000_1100_0000_0;
        if (step == 6) v = 17'b0000_0000_0010_0100_1;
      end else if (op <= 3) begin
        if (step == 3) v = take ? 17'b0000_0000_1100_0010_0 : 17'b0000_0000_0000_0000_1;
        if (step == 4) v = 17'b0100_0000_0010_0000_1;
      end else if (step == 3) begin
        v = 17'b0000_0000_0000_0000_1;
      end
    end
    return v;
  endfunction

  always @(negedge clk) begin
    logic [16:0] act, exp_v;
    string tag;
    cycles++;
    act = {pc_out, pc_load, mar_load, mem_read, mdr_out, ir_load, y_load, sel_const,
           alu_add, z_load, z_out, src_out, dst_out, dst_in, offset_out, wait_mem, end_seq};
    if (!rst_n || !run) exp_v = '0;
    else exp_v = expect_ctrl(mstep, int'(ir_opcode), cond_flags);
    if (!rst_n) tag = "R1";
    else if (!run) tag = "R3";
    else if (prev_end) tag = "R9";
    else if (exp_v[1] && !mfc) tag = "R5";
    else if (mstep < 3) tag = "R4 R2";
    else if (ir_opcode == 0) tag = "R6";
    else if (ir_opcode == 1) tag = "R7";
    else if (ir_opcode <= 3) tag = "R8";
    else tag = "R10";
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s step=%0d op=%0d actual=%b expected=%b", tag, mstep, ir_opcode, act, exp_v);
    end
    checks++;
    if ($countones({pc_out, z_out, mdr_out, src_out, dst_out, offset_out}) > 1) begin
      errors++;
      $display("FAIL R11 bus drivers actual=%b expected=at most one",
               {pc_out, z_out, mdr_out, src_out, dst_out, offset_out});
    end
    prev_end = rst_n && run && exp_v[0];
    if (!rst_n) mstep = 0;
    else if (run) begin
      if (exp_v[0]) mstep = 0;
      else if (!(exp_v[1] && !mfc)) mstep = (mstep + 1) % 8;
    end
  end

  task automatic phase(int op, int fl, int mper, int rgap, int n);
    for (int c = 0; c < n; c++) begin
      @(posedge clk); #1;
      ir_opcode = 3'(op);
      cond_flags = 4'(fl);
      mfc = (c % mper) == 0;
      run = (rgap == 0) ? 1'b1 : ((c % rgap) != 0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1; run = 1'b1;
    for (int op = 0; op < 8; op++)
      for (int fl = 0; fl < 16; fl += 4)
        for (int mp = 1; mp <= 3; mp++)
          phase(op, fl, mp, 0, 40);
    for (int op = 0; op < 4; op++) phase(op, 12, 2, 3, 50);
    phase(0, 0, 1, 0, 5);
    @(posedge clk); #1 rst_n = 1'b0;
    phase(0, 0, 1, 0, 3);
    @(posedge clk); #1 rst_n = 1'b1;
    for (int op = 0; op < 8; op++) phase(op, 8, 3, 5, 40);
    done = 1'b1;
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule